// File: doc/BRIEF.md
# USB Pipe Data-Toggle and Configuration Write Guard

This block keeps the DATA0/DATA1 data-toggle state for every pipe of a USB controller. It also decides, pipe by pipe, whether a configuration write may land. The transaction engine reports each handshake with its pipe, its handshake type and its transfer type. The toggle of that pipe advances only when the ACK belongs to the pipe's direction: an ACK received after the pipe sent data, or an ACK sent after the pipe took data in. Software may force a toggle to DATA0 or DATA1. A per-pipe monitor output always shows the PID the next data packet on that pipe will carry.

Configuration writes come in two classes. Setup writes cover type, buffer, maximum packet size and polling period. Transfer writes cover the transaction counters and the device address. A write is admitted only when all of these hold:
- the pipe's response mode is NAK;
- its busy flag is clear;
- in host mode, its split-transaction flag is clear.

A setup write is also refused while the pipe is the current selection of any FIFO port. A refused write leaves the stored value untouched and raises a one-cycle error pulse. An admitted setup write to pipe 0 (the default control pipe) produces a buffer-clear request pulse.

Top module: `pipe_seq_guard`

## Requirements
- R1: A handshake advances the pipe's toggle only for control, bulk or interrupt transfers. The transfer type is coded on `hsXfer` as 0 control, 1 isochronous, 2 bulk, 3 interrupt. A transmitting pipe (`pipeIsTx`=1) toggles on ACK received (`hsType`=0). A receiving pipe toggles on ACK sent (`hsType`=1).
- R2: The toggle is left unchanged by an ACK of the wrong direction, by NAK (`hsType`=2), by STALL or timeout (`hsType`=3), and by any isochronous handshake.
- R3: `seqMon[p]` shows the next data PID of pipe p, with 0 meaning DATA0 and 1 meaning DATA1. All bits reset to DATA0, and all strobes and stored values reset to 0.
- R4: An accepted clear request forces DATA0 and an accepted set request forces DATA1. When both arrive together, clear wins. An accepted request overrides a hardware toggle on the same pipe in the same cycle.
- R5: A set or clear request on a pipe whose `pipeBuf` is 1 (BUF mode) is rejected. The toggle is kept and `wrErr` pulses.
- R6: A configuration write is rejected while the pipe is in BUF mode or its `pipeBusy` is 1. The stored value is kept and `wrErr` pulses. An accepted write pulses `cfgWrOk` and stores the data, with `cfgWrClass` 1 for setup and 0 for transfer.
- R7: While `hostMode` is 1, a configuration write to a pipe whose `splitBusy` is 1 is rejected. While `hostMode` is 0, `splitBusy` has no effect.
- R8: A setup-class write is rejected when any FIFO port k has `fifoSelVld[k]`=1 and selects that pipe in `fifoSel[k*PIPE_W +: PIPE_W]`. A transfer-class write ignores the FIFO selections.
- R9: An accepted setup-class write to pipe 0 gives a one-cycle `bufClrReq`. Other pipes and transfer-class writes do not.
- R10: `cfgWrAllow[p]` is combinationally 1 exactly when pipe p is in NAK mode, is not busy, and is not split-busy in host mode.
- R11: `seqMon`, `wrErr`, `cfgWrOk` and `bufClrReq` update on the first clock edge after the request, and the pulses last one cycle. `rdSetup` and `rdXfer` follow `rdPipe` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pipeIsTx | input | NUM_PIPES | 1 = pipe transmits data |
| pipeBuf | input | NUM_PIPES | Response mode, 1 = BUF, 0 = NAK |
| pipeBusy | input | NUM_PIPES | Pipe still busy after switch to NAK |
| splitBusy | input | NUM_PIPES | Split transaction in progress |
| hostMode | input | 1 | 1 = host operation |
| hsValid | input | 1 | Handshake event valid |
| hsPipe | input | PIPE_W | Pipe of the handshake |
| hsType | input | 2 | 0 ACK rcvd, 1 ACK sent, 2 NAK, 3 STALL/timeout |
| hsXfer | input | 2 | 0 control, 1 iso, 2 bulk, 3 interrupt |
| seqClrReq | input | 1 | Force DATA0 request |
| seqSetReq | input | 1 | Force DATA1 request |
| seqReqPipe | input | PIPE_W | Pipe of the toggle request |
| cfgWrEn | input | 1 | Configuration write request |
| cfgWrClass | input | 1 | 1 setup class, 0 transfer class |
| cfgWrPipe | input | PIPE_W | Pipe of the write |
| cfgWrData | input | CFG_W | Write data |
| fifoSelVld | input | NUM_FIFO | FIFO port selection valid |
| fifoSel | input | NUM_FIFO*PIPE_W | Current pipe of each FIFO port |
| rdPipe | input | PIPE_W | Pipe for read-back |
| seqMon | output | NUM_PIPES | Next data PID per pipe |
| cfgWrAllow | output | NUM_PIPES | Pipe may accept a configuration write |
| cfgWrOk | output | 1 | Write accepted pulse |
| wrErr | output | 1 | Rejected request pulse |
| bufClrReq | output | 1 | Buffer clear request for pipe 0 |
| rdSetup | output | CFG_W | Setup value of `rdPipe` |
| rdXfer | output | CFG_W | Transfer value of `rdPipe` |

## Verification
Every registered result (`seqMon`, `wrErr`, `cfgWrOk`, `bufClrReq`) is due on the first rising edge after the request is presented. The bench drives a request on a falling edge and removes it on the next falling edge, then samples at that falling edge, half a cycle after the result was registered. Pulses are checked again one cycle later to confirm they have dropped. `cfgWrAllow` and the read-back values are combinational and are sampled one time unit after the inputs change.

// File: rtl/psg_pkg.sv
package psg_pkg;
  localparam logic [1:0] HS_ACK_RCVD = 2'd0;
  localparam logic [1:0] HS_ACK_SENT = 2'd1;
  localparam logic [1:0] XFER_ISO    = 2'd1;

  typedef struct packed {
    logic seqLoad;  // software value load
    logic seqVal;   // value to load
    logic togEn;    // hardware toggle
    logic setupWe;  // setup-class store
    logic xferWe;   // transfer-class store
  } psg_strobe_t;
endpackage

// File: rtl/psg_ctrl.sv
module psg_ctrl
  import psg_pkg::*;
#(
  parameter int NUM_PIPES = 8,
  parameter int NUM_FIFO  = 3,
  parameter int PIPE_W    = 3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_PIPES-1:0]       pipeIsTx,
  input  logic [NUM_PIPES-1:0]       pipeBuf,
  input  logic [NUM_PIPES-1:0]       pipeBusy,
  input  logic [NUM_PIPES-1:0]       splitBusy,
  input  logic                       hostMode,
  input  logic                       hsValid,
  input  logic [PIPE_W-1:0]          hsPipe,
  input  logic [1:0]                 hsType,
  input  logic [1:0]                 hsXfer,
  input  logic                       seqClrReq,
  input  logic                       seqSetReq,
  input  logic [PIPE_W-1:0]          seqReqPipe,
  input  logic                       cfgWrEn,
  input  logic                       cfgWrClass,
  input  logic [PIPE_W-1:0]          cfgWrPipe,
  input  logic [NUM_FIFO-1:0]        fifoSelVld,
  input  logic [NUM_FIFO*PIPE_W-1:0] fifoSel,
  output psg_strobe_t                stb,
  output logic [NUM_PIPES-1:0]       cfgWrAllow,
  output logic                       cfgWrOk,
  output logic                       wrErr,
  output logic                       bufClrReq
);
  logic fifoHit, seqReq, seqAcc, seqRej, wrAcc, wrRej, togHit, dirMatch;

  always_comb begin
    fifoHit = 1'b0;
    for (int k = 0; k < NUM_FIFO; k++)
      if (fifoSelVld[k] && fifoSel[k*PIPE_W +: PIPE_W] == cfgWrPipe) fifoHit = 1'b1;
  end

  assign cfgWrAllow = ~pipeBuf & ~pipeBusy & ~({NUM_PIPES{hostMode}} & splitBusy);

  assign seqReq = seqClrReq | seqSetReq;
  assign seqAcc = seqReq & ~pipeBuf[seqReqPipe];
  assign seqRej = seqReq & pipeBuf[seqReqPipe];
  assign wrAcc  = cfgWrEn & cfgWrAllow[cfgWrPipe] & ~(cfgWrClass & fifoHit);
  assign wrRej  = cfgWrEn & ~wrAcc;

  assign dirMatch = pipeIsTx[hsPipe] ? (hsType == HS_ACK_RCVD) : (hsType == HS_ACK_SENT);
  assign togHit   = hsValid & (hsXfer != XFER_ISO) & dirMatch;

  always_comb begin
    stb.seqLoad = seqAcc;
    stb.seqVal  = seqSetReq & ~seqClrReq;
    stb.togEn   = togHit & ~(seqAcc && hsPipe == seqReqPipe);
    stb.setupWe = wrAcc & cfgWrClass;
    stb.xferWe  = wrAcc & ~cfgWrClass;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgWrOk   <= 1'b0;
      wrErr     <= 1'b0;
      bufClrReq <= 1'b0;
    end else begin
      cfgWrOk   <= wrAcc;
      wrErr     <= seqRej | wrRej;
      bufClrReq <= wrAcc & cfgWrClass & (cfgWrPipe == '0);
    end
  end

  AST_BUF_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && (pipeBuf[cfgWrPipe] || pipeBusy[cfgWrPipe])) |=> (wrErr && !cfgWrOk)); // R6
  AST_SPLIT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && hostMode && splitBusy[cfgWrPipe]) |=> wrErr); // R7
  AST_FIFO_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && cfgWrClass && fifoHit) |=> !cfgWrOk); // R8
  AST_BUFCLR_SRC: assert property (@(posedge clk) disable iff (!rstN)
    bufClrReq |-> (cfgWrOk && $past(cfgWrPipe) == '0 && $past(cfgWrClass))); // R9
  AST_SEQ_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    ((seqClrReq || seqSetReq) && pipeBuf[seqReqPipe]) |=> wrErr); // R5
endmodule

// File: rtl/psg_datapath.sv
module psg_datapath
  import psg_pkg::*;
#(
  parameter int NUM_PIPES = 8,
  parameter int CFG_W     = 16,
  parameter int PIPE_W    = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  psg_strobe_t          stb,
  input  logic [PIPE_W-1:0]    seqPipe,
  input  logic [PIPE_W-1:0]    togPipe,
  input  logic [PIPE_W-1:0]    wrPipe,
  input  logic [CFG_W-1:0]     wrData,
  input  logic [PIPE_W-1:0]    rdPipe,
  output logic [NUM_PIPES-1:0] seqQ,
  output logic [CFG_W-1:0]     rdSetup,
  output logic [CFG_W-1:0]     rdXfer
);
  logic [CFG_W-1:0] setupQ [NUM_PIPES];
  logic [CFG_W-1:0] xferQ  [NUM_PIPES];

  for (genvar p = 0; p < NUM_PIPES; p++) begin : g_pipe
    always_ff @(posedge clk) begin
      if (!rstN) begin
        seqQ[p]   <= 1'b0;
        setupQ[p] <= '0;
        xferQ[p]  <= '0;
      end else begin
        if (stb.seqLoad && seqPipe == PIPE_W'(p)) seqQ[p] <= stb.seqVal;
        else if (stb.togEn && togPipe == PIPE_W'(p)) seqQ[p] <= ~seqQ[p];
        if (stb.setupWe && wrPipe == PIPE_W'(p)) setupQ[p] <= wrData;
        if (stb.xferWe && wrPipe == PIPE_W'(p)) xferQ[p] <= wrData;
      end
    end
  end

  assign rdSetup = setupQ[rdPipe];
  assign rdXfer  = xferQ[rdPipe];

  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (stb.seqLoad && !stb.seqVal) |=> !seqQ[$past(seqPipe)]); // R4
  AST_SETUP_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.setupWe) |=> (setupQ[$past(wrPipe)] == $past(setupQ[wrPipe]))); // R6
endmodule

// File: rtl/pipe_seq_guard.sv
module pipe_seq_guard
  import psg_pkg::*;
#(
  parameter int NUM_PIPES = 8,
  parameter int CFG_W     = 16,
  parameter int NUM_FIFO  = 3,
  localparam int PIPE_W   = $clog2(NUM_PIPES)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_PIPES-1:0]       pipeIsTx,
  input  logic [NUM_PIPES-1:0]       pipeBuf,
  input  logic [NUM_PIPES-1:0]       pipeBusy,
  input  logic [NUM_PIPES-1:0]       splitBusy,
  input  logic                       hostMode,
  input  logic                       hsValid,
  input  logic [PIPE_W-1:0]          hsPipe,
  input  logic [1:0]                 hsType,
  input  logic [1:0]                 hsXfer,
  input  logic                       seqClrReq,
  input  logic                       seqSetReq,
  input  logic [PIPE_W-1:0]          seqReqPipe,
  input  logic                       cfgWrEn,
  input  logic                       cfgWrClass,
  input  logic [PIPE_W-1:0]          cfgWrPipe,
  input  logic [CFG_W-1:0]           cfgWrData,
  input  logic [NUM_FIFO-1:0]        fifoSelVld,
  input  logic [NUM_FIFO*PIPE_W-1:0] fifoSel,
  input  logic [PIPE_W-1:0]          rdPipe,
  output logic [NUM_PIPES-1:0]       seqMon,
  output logic [NUM_PIPES-1:0]       cfgWrAllow,
  output logic                       cfgWrOk,
  output logic                       wrErr,
  output logic                       bufClrReq,
  output logic [CFG_W-1:0]           rdSetup,
  output logic [CFG_W-1:0]           rdXfer
);
  psg_strobe_t stb;

  psg_ctrl #(.NUM_PIPES(NUM_PIPES), .NUM_FIFO(NUM_FIFO), .PIPE_W(PIPE_W)) u_ctrl (
    .clk, .rstN, .pipeIsTx, .pipeBuf, .pipeBusy, .splitBusy, .hostMode,
    .hsValid, .hsPipe, .hsType, .hsXfer, .seqClrReq, .seqSetReq, .seqReqPipe,
    .cfgWrEn, .cfgWrClass, .cfgWrPipe, .fifoSelVld, .fifoSel,
    .stb, .cfgWrAllow, .cfgWrOk, .wrErr, .bufClrReq
  );

  psg_datapath #(.NUM_PIPES(NUM_PIPES), .CFG_W(CFG_W), .PIPE_W(PIPE_W)) u_dp (
    .clk, .rstN, .stb, .seqPipe(seqReqPipe), .togPipe(hsPipe), .wrPipe(cfgWrPipe),
    .wrData(cfgWrData), .rdPipe, .seqQ(seqMon), .rdSetup, .rdXfer
  );

  AST_ISO_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (hsValid && hsXfer == XFER_ISO && !seqClrReq && !seqSetReq)
      |=> (seqMon[$past(hsPipe)] == $past(seqMon[hsPipe]))); // R2
endmodule

// File: tb/pipe_seq_guard_bench.sv
module pipe_seq_guard_bench;
  localparam int NP = 8;
  localparam int PW = 3;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NP-1:0] pipeIsTx = '0, pipeBuf = '0, pipeBusy = '0, splitBusy = '0;
  logic hostMode = 1'b0, hsValid = 1'b0, seqClrReq = 1'b0, seqSetReq = 1'b0;
  logic cfgWrEn = 1'b0, cfgWrClass = 1'b0;
  logic [PW-1:0] hsPipe = '0, seqReqPipe = '0, cfgWrPipe = '0, rdPipe = '0;
  logic [1:0] hsType = '0, hsXfer = '0;
  logic [CW-1:0] cfgWrData = '0;
  logic [2:0] fifoSelVld = '0;
  logic [3*PW-1:0] fifoSel = '0;
  logic [NP-1:0] seqMon, cfgWrAllow;
  logic cfgWrOk, wrErr, bufClrReq;
  logic [CW-1:0] rdSetup, rdXfer;

  int vecs = 0;
  int errs = 0;
  logic [NP-1:0] expSeq = '0;

  always #5 clk = ~clk;

  pipe_seq_guard u_pipe_seq_guard (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hs(input int p, input logic [1:0] t, input logic [1:0] x);
    @(negedge clk);
    hsValid = 1'b1; hsPipe = PW'(p); hsType = t; hsXfer = x;
    @(negedge clk);
    hsValid = 1'b0;
  endtask

  task automatic swReq(input int p, input logic clr, input logic set);
    @(negedge clk);
    seqReqPipe = PW'(p); seqClrReq = clr; seqSetReq = set;
    @(negedge clk);
    seqClrReq = 1'b0; seqSetReq = 1'b0;
  endtask

  task automatic wr(input int p, input logic cls, input logic [CW-1:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrPipe = PW'(p); cfgWrClass = cls; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic t_reset();
    chk("R3 seqMon reset", 32'(seqMon), 0);
    chk("R3 wrErr reset", 32'(wrErr), 0);
    chk("R3 cfgWrOk reset", 32'(cfgWrOk), 0);
    chk("R3 bufClrReq reset", 32'(bufClrReq), 0);
    rdPipe = 3'd5; #1;
    chk("R3 setup reset", 32'(rdSetup), 0);
  endtask

  task automatic t_ack();
    pipeIsTx = 8'b0000_1011;
    hs(1, 2'd0, 2'd2); expSeq[1] = 1'b1;
    chk("R1 tx bulk ACK rcvd", 32'(seqMon), 32'(expSeq));
    hs(2, 2'd1, 2'd3); expSeq[2] = 1'b1;
    chk("R1 rx intr ACK sent", 32'(seqMon), 32'(expSeq));
    hs(3, 2'd0, 2'd0); expSeq[3] = 1'b1;
    chk("R1 tx control ACK rcvd", 32'(seqMon), 32'(expSeq));
    hs(1, 2'd0, 2'd2); expSeq[1] = 1'b0;
    chk("R1 second toggle", 32'(seqMon), 32'(expSeq));
  endtask

  task automatic t_noToggle();
    hs(1, 2'd1, 2'd2);
    chk("R2 tx pipe ACK sent", 32'(seqMon), 32'(expSeq));
    hs(2, 2'd0, 2'd2);
    chk("R2 rx pipe ACK rcvd", 32'(seqMon), 32'(expSeq));
    hs(3, 2'd2, 2'd2);
    chk("R2 NAK", 32'(seqMon), 32'(expSeq));
    hs(3, 2'd3, 2'd3);
    chk("R2 STALL", 32'(seqMon), 32'(expSeq));
    hs(4, 2'd1, 2'd1);
    chk("R2 isochronous", 32'(seqMon), 32'(expSeq));
  endtask

  task automatic t_swSeq();
    swReq(3, 1'b1, 1'b0); expSeq[3] = 1'b0;
    chk("R4 clear", 32'(seqMon), 32'(expSeq));
    swReq(5, 1'b0, 1'b1); expSeq[5] = 1'b1;
    chk("R4 set", 32'(seqMon), 32'(expSeq));
    swReq(5, 1'b1, 1'b1); expSeq[5] = 1'b0;
    chk("R4 clear wins", 32'(seqMon), 32'(expSeq));
    @(negedge clk);
    seqReqPipe = 3'd2; seqSetReq = 1'b1;
    hsValid = 1'b1; hsPipe = 3'd2; hsType = 2'd1; hsXfer = 2'd2;
    @(negedge clk);
    seqSetReq = 1'b0; hsValid = 1'b0; expSeq[2] = 1'b1;
    chk("R4 request overrides toggle", 32'(seqMon), 32'(expSeq));
  endtask

  task automatic t_seqBuf();
    pipeBuf[2] = 1'b1;
    swReq(2, 1'b1, 1'b0);
    chk("R5 seq kept in BUF", 32'(seqMon), 32'(expSeq));
    chk("R5 wrErr pulse", 32'(wrErr), 1);
    @(negedge clk);
    chk("R11 wrErr one cycle", 32'(wrErr), 0);
    pipeBuf = '0;
  endtask

  task automatic t_allow();
    pipeBuf = 8'h01; pipeBusy = 8'h02; splitBusy = 8'h04; hostMode = 1'b1; #1;
    chk("R10 allow host", 32'(cfgWrAllow), 32'h0F8);
    hostMode = 1'b0; #1;
    chk("R10 allow device", 32'(cfgWrAllow), 32'h0FC);
    pipeBuf = '0; pipeBusy = '0; splitBusy = '0;
  endtask

  task automatic t_cfgGuard();
    rdPipe = 3'd4;
    wr(4, 1'b0, 16'h1234);
    chk("R6 accept ok", 32'(cfgWrOk), 1);
    chk("R6 accept no err", 32'(wrErr), 0);
    chk("R6 stored", 32'(rdXfer), 32'h1234);
    pipeBuf[4] = 1'b1;
    wr(4, 1'b0, 16'h5555);
    chk("R6 BUF err", 32'(wrErr), 1);
    chk("R6 BUF kept", 32'(rdXfer), 32'h1234);
    pipeBuf[4] = 1'b0; pipeBusy[4] = 1'b1;
    wr(4, 1'b0, 16'h5555);
    chk("R6 busy err", 32'(wrErr), 1);
    chk("R6 busy kept", 32'(rdXfer), 32'h1234);
    pipeBusy = '0;
    @(negedge clk);
    chk("R11 cfgWrOk idle", 32'(cfgWrOk), 0);
  endtask

  task automatic t_split();
    hostMode = 1'b1; splitBusy[4] = 1'b1;
    wr(4, 1'b0, 16'h7777);
    chk("R7 host split err", 32'(wrErr), 1);
    chk("R7 host split kept", 32'(rdXfer), 32'h1234);
    hostMode = 1'b0;
    wr(4, 1'b0, 16'h7777);
    chk("R7 device ignores split", 32'(cfgWrOk), 1);
    chk("R7 device stored", 32'(rdXfer), 32'h7777);
    splitBusy = '0;
  endtask

  task automatic t_fifo();
    rdPipe = 3'd6;
    fifoSelVld = 3'b100; fifoSel[2*PW +: PW] = 3'd6;
    wr(6, 1'b1, 16'hAAAA);
    chk("R8 setup locked err", 32'(wrErr), 1);
    chk("R8 setup locked kept", 32'(rdSetup), 0);
    wr(6, 1'b0, 16'hBBBB);
    chk("R8 xfer class passes", 32'(rdXfer), 32'hBBBB);
    fifoSelVld = 3'b000;
    wr(6, 1'b1, 16'hAAAA);
    chk("R8 invalid sel passes", 32'(rdSetup), 32'hAAAA);
    fifoSelVld = 3'b001; fifoSel[0 +: PW] = 3'd5;
    wr(5, 1'b1, 16'hCCCC);
    chk("R8 CPU port lock", 32'(wrErr), 1);
    fifoSelVld = '0;
  endtask

  task automatic t_bufClr();
    wr(0, 1'b1, 16'h0040);
    chk("R9 bufClrReq pulse", 32'(bufClrReq), 1);
    @(negedge clk);
    chk("R11 bufClrReq one cycle", 32'(bufClrReq), 0);
    wr(1, 1'b1, 16'h0040);
    chk("R9 other pipe no clear", 32'(bufClrReq), 0);
    wr(0, 1'b0, 16'h0003);
    chk("R9 xfer class no clear", 32'(bufClrReq), 0);
  endtask

  initial begin
    #2_000_000;
    errs++;
    $display("FAIL R11 watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_ack();
    t_noToggle();
    t_swSeq();
    t_seqBuf();
    t_allow();
    t_cfgGuard();
    t_split();
    t_fifo();
    t_bufClr();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule